// File: doc/BRIEF.md
# Card Function Configuration and Status Register

This block holds one byte-wide configuration and status register for each function of a multi-function removable card. By default it is built with two functions. A host writes and reads each register through a byte port with an address decode. Each register controls four things for its function: how the function's interrupt request is reported, whether the function may drive the shared status-change pin, whether the function's audio reaches the speaker output, and whether the function should enter power-down.

The pending-interrupt bit has two modes, chosen by an acknowledge-mode bit in the same register. In live mode the bit follows the function's internal request. In sticky mode the bit latches a request and holds it until host software writes a 0 to it. Sticky mode lets several functions share one active-low interrupt line. A second field reports whether any of the function's pin-replacement status inputs is set. The change pin carries that report only in I/O interface mode, and only for functions that enable it. A power-down request reaches the function only while the card's READY input is high.

Top module: `card_fcsr`

## Requirements
- R1: Function f's register is at address BASE_ADDR + f*ADDR_STRIDE (defaults: 0x402 and 0x442). A read of any other address returns 0x00, and a write to any other address changes no register.
- R2: The register bits are: bit 7 change-seen, bit 6 change enable, bit 5 narrow-I/O flag, bit 4 spare, bit 3 audio enable, bit 2 power-down, bit 1 interrupt pending, bit 0 acknowledge mode. Bits 6, 3, 2 and 0 read back the last value written. Bits 5 and 4 always read 0, whatever is written to them.
- R3: After a clock with rst_n low, every register reads 0x00 (with pin status and interrupt sources low), chg_n and ireq_n are 1, and pwrdn_req is 0.
- R4: In live mode (bit 0 = 0), bit 1 equals the function's irq_src as sampled at the previous clock. A host write to bit 1 has no effect in this mode.
- R5: In sticky mode (bit 0 = 1), bit 1 sets on a clock where irq_src is 1 and stays set after irq_src returns to 0. A host write that carries 0 in bit 1 clears it. A write that carries 1 in bit 1 leaves it unchanged.
- R6: In sticky mode, if irq_src is still 1 when a clear is written, bit 1 reads 0 for the one clock after the clearing write and is set again at the following clock.
- R7: Bit 7 equals the OR of the function's four pin_status inputs as sampled at the previous clock. Function f uses pin_status[4f+3:4f].
- R8: chg_n is 0 exactly when io_mode is 1 and some function has both bit 6 and bit 7 set. Otherwise chg_n is 1.
- R9: spkr_out is 1 exactly when io_mode is 1 and some function has bit 3 set while its audio_in is 1.
- R10: While ready is 1, pwrdn_req[f] takes the value of function f's bit 2 at each clock. While ready is 0, pwrdn_req[f] holds its value.
- R11: ireq_n is 0 exactly when at least one function's bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | ADDR_W | Register address for host read and write |
| host_wr_en | input | 1 | Host write strobe, sampled on the clock |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| io_mode | input | 1 | Card is configured for the I/O interface |
| ready | input | 1 | Card READY; low means busy |
| irq_src | input | NUM_FUNC | Internal interrupt request of each function |
| pin_status | input | NUM_FUNC*4 | Pin-replacement status bits, four per function |
| audio_in | input | NUM_FUNC | Audio bit stream of each function |
| chg_n | output | 1 | Status-change pin, active low |
| spkr_out | output | 1 | Gated speaker audio |
| pwrdn_req | output | NUM_FUNC | Power-down request for each function |
| ireq_n | output | 1 | Shared interrupt request, active low |

## Verification
The bench uses the default parameters: two functions at 0x402 and 0x442 with a 12-bit address. With two functions, the bench can put one function in live mode and the other in sticky mode and watch both drive the shared interrupt line. It can also check that a write to one function's address, or to an address that decodes to neither, leaves the other register unchanged. The 0x40 stride is small enough that an address between the two registers can be tried as a non-match.

// File: rtl/cfgsr_pkg.sv
// Package: shared constants for the card function configuration-status register.
// Assumes: one register byte per function; field positions are fixed because
// host software decodes them.
package cfgsr_pkg;
    localparam int REG_W       = 8;
    localparam int PIN_BITS    = 4;
    localparam int BIT_CHNG    = 7;
    localparam int BIT_CHG_EN  = 6;
    localparam int BIT_NARROW  = 5;
    localparam int BIT_SPARE   = 4;
    localparam int BIT_AUDIO   = 3;
    localparam int BIT_PWRDN   = 2;
    localparam int BIT_INTR    = 1;
    localparam int BIT_ACKMODE = 0;
endpackage

// File: rtl/cfgsr_func.sv
// Module: one function's configuration-status register.
// Holds the writable control bits and the interrupt-pending bit (live or
// sticky), samples the pin-status OR, and gates the power-down request by READY.
// Assumes: wr_sel is already decoded for this function; synchronous active-low reset.
module cfgsr_func
    import cfgsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_sel,
    input  logic [REG_W-1:0]    wdata,
    input  logic                irq_src,
    input  logic [PIN_BITS-1:0] pin_status,
    input  logic                ready,
    output logic [REG_W-1:0]    rd_byte,
    output logic                intr,
    output logic                chg_req,
    output logic                audio_en,
    output logic                pwrdn_req
);
    logic chng_q, chg_en_q, audio_q, pwrdn_q, intr_q, ack_q, pd_active_q;
    logic clr_hit;
    logic intr_nxt;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[BIT_CHNG], wdata[BIT_NARROW], wdata[BIT_SPARE]};

    // Purpose: a sticky-mode write carrying 0 in the pending bit.
    assign clr_hit = wr_sel && ack_q && !wdata[BIT_INTR];

    // Purpose: next pending value: live copy, or latch-until-clear in sticky mode.
    always_comb begin
        if (!ack_q)       intr_nxt = irq_src;
        else if (clr_hit) intr_nxt = 1'b0;
        else              intr_nxt = intr_q | irq_src;
    end

    // Purpose: host-writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_en_q <= 1'b0;
            audio_q  <= 1'b0;
            pwrdn_q  <= 1'b0;
            ack_q    <= 1'b0;
        end else if (wr_sel) begin
            chg_en_q <= wdata[BIT_CHG_EN];
            audio_q  <= wdata[BIT_AUDIO];
            pwrdn_q  <= wdata[BIT_PWRDN];
            ack_q    <= wdata[BIT_ACKMODE];
        end
    end

    // Purpose: status state: pending bit and sampled pin-status OR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intr_q <= 1'b0;
            chng_q <= 1'b0;
        end else begin
            intr_q <= intr_nxt;
            chng_q <= |pin_status;
        end
    end

    // Purpose: power-down request moves only while the card is not busy.
    always_ff @(posedge clk) begin
        if (!rst_n)     pd_active_q <= 1'b0;
        else if (ready) pd_active_q <= pwrdn_q;
    end

    assign rd_byte   = {chng_q, chg_en_q, 1'b0, 1'b0, audio_q, pwrdn_q, intr_q, ack_q};
    assign intr      = intr_q;
    assign chg_req   = chg_en_q & chng_q;
    assign audio_en  = audio_q;
    assign pwrdn_req = pd_active_q;

    // R4: in live mode the pending bit is last clock's request
    a_r4_live_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_q) |=> (intr_q == $past(irq_src)));
    // R5: a set sticky bit survives any clock without a clearing write
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && intr_q && !(wr_sel && !wdata[BIT_INTR])) |=> intr_q);
    // R5: a clearing write in sticky mode drops the bit
    a_r5_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && wr_sel && !wdata[BIT_INTR]) |=> !intr_q);
    // R10: request frozen while busy
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) |=> $stable(pwrdn_req));
    // R10: request tracks the written bit while ready
    a_r10_ready_track: assert property (@(posedge clk) disable iff (!rst_n)
        (ready) |=> (pwrdn_req == $past(rd_byte[BIT_PWRDN])));
endmodule

// File: rtl/cfgsr_merge.sv
// Module: merges the per-function outputs into the shared pins and the read bus.
// Assumes: at most one select bit is set (addresses are distinct).
module cfgsr_merge
    import cfgsr_pkg::*;
#(
    parameter int NUM_FUNC = 2
) (
    input  logic [NUM_FUNC-1:0]       rd_sel,
    input  logic [NUM_FUNC*REG_W-1:0] rd_bytes,
    input  logic [NUM_FUNC-1:0]       intr,
    input  logic [NUM_FUNC-1:0]       chg_req,
    input  logic [NUM_FUNC-1:0]       audio_en,
    input  logic [NUM_FUNC-1:0]       audio_in,
    input  logic                      io_mode,
    output logic [REG_W-1:0]          rdata,
    output logic                      chg_n,
    output logic                      ireq_n,
    output logic                      spkr_out
);
    // Purpose: AND-OR read mux over the selected function.
    always_comb begin
        rdata = '0;
        for (int f = 0; f < NUM_FUNC; f++) begin
            if (rd_sel[f]) rdata = rdata | rd_bytes[f*REG_W +: REG_W];
        end
    end

    // Purpose: shared pins, gated by interface mode where required.
    assign chg_n    = !(io_mode && (|chg_req));
    assign ireq_n   = !(|intr);
    assign spkr_out = io_mode && (|(audio_en & audio_in));
endmodule

// File: rtl/card_fcsr.sv
// Module: top of the per-function configuration-status registers.
// Decodes the host address to one register per function, instantiates them,
// and drives the shared change, speaker and interrupt pins.
// Assumes: BASE_ADDR + f*ADDR_STRIDE are distinct and fit in ADDR_W bits.
module card_fcsr
    import cfgsr_pkg::*;
#(
    parameter int NUM_FUNC    = 2,
    parameter int ADDR_W      = 12,
    parameter int BASE_ADDR   = 'h402,
    parameter int ADDR_STRIDE = 'h40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            host_addr,
    input  logic                         host_wr_en,
    input  logic [REG_W-1:0]             host_wdata,
    output logic [REG_W-1:0]             host_rdata,
    input  logic                         io_mode,
    input  logic                         ready,
    input  logic [NUM_FUNC-1:0]          irq_src,
    input  logic [NUM_FUNC*PIN_BITS-1:0] pin_status,
    input  logic [NUM_FUNC-1:0]          audio_in,
    output logic                         chg_n,
    output logic                         spkr_out,
    output logic [NUM_FUNC-1:0]          pwrdn_req,
    output logic                         ireq_n
);
    logic [NUM_FUNC-1:0]       sel;
    logic [NUM_FUNC*REG_W-1:0] rd_bytes;
    logic [NUM_FUNC-1:0]       intr_v, chg_req_v, audio_en_v;

    for (genvar f = 0; f < NUM_FUNC; f++) begin : g_func
        localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(BASE_ADDR + f * ADDR_STRIDE);

        // Purpose: address decode for this function.
        assign sel[f] = (host_addr == FADDR);

        cfgsr_func u_func (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (host_wr_en && sel[f]),
            .wdata      (host_wdata),
            .irq_src    (irq_src[f]),
            .pin_status (pin_status[f*PIN_BITS +: PIN_BITS]),
            .ready      (ready),
            .rd_byte    (rd_bytes[f*REG_W +: REG_W]),
            .intr       (intr_v[f]),
            .chg_req    (chg_req_v[f]),
            .audio_en   (audio_en_v[f]),
            .pwrdn_req  (pwrdn_req[f])
        );
    end

    cfgsr_merge #(.NUM_FUNC(NUM_FUNC)) u_merge (
        .rd_sel   (sel),
        .rd_bytes (rd_bytes),
        .intr     (intr_v),
        .chg_req  (chg_req_v),
        .audio_en (audio_en_v),
        .audio_in (audio_in),
        .io_mode  (io_mode),
        .rdata    (host_rdata),
        .chg_n    (chg_n),
        .ireq_n   (ireq_n),
        .spkr_out (spkr_out)
    );

    // R8: outside I/O mode the change pin stays deasserted
    a_r8_chg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_mode) |-> chg_n);
    // R11: a pending bit in any function pulls the shared line low
    a_r11_ireq_low: assert property (@(posedge clk) disable iff (!rst_n)
        (|intr_v) |-> !ireq_n);
endmodule

// File: tb/sim_card_fcsr.sv
// Bench: directed tests for card_fcsr, one task per scenario.
module sim_card_fcsr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] host_addr = '0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        io_mode = 1'b0;
    logic        ready = 1'b1;
    logic [1:0]  irq_src = '0;
    logic [7:0]  pin_status = '0;
    logic [1:0]  audio_in = '0;
    logic        chg_n, spkr_out, ireq_n;
    logic [1:0]  pwrdn_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [11:0] A0 = 12'h402;
    localparam logic [11:0] A1 = 12'h442;

    always #2.5 clk = ~clk;

    card_fcsr u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .io_mode(io_mode),
        .ready(ready), .irq_src(irq_src), .pin_status(pin_status),
        .audio_in(audio_in), .chg_n(chg_n), .spkr_out(spkr_out),
        .pwrdn_req(pwrdn_req), .ireq_n(ireq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr_en = 1'b1;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(A0, d); check("R3 reg0", d, 8'h00);
        rd(A1, d); check("R3 reg1", d, 8'h00);
        check("R3 chg_n", {7'd0, chg_n}, 8'h01);
        check("R3 ireq_n", {7'd0, ireq_n}, 8'h01);
        check("R3 pwrdn_req", {6'd0, pwrdn_req}, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(A0, 8'hFF);
        rd(A0, d); check("R2 writable bits, spare and narrow read 0", d, 8'h4D);
        rd(A1, d); check("R1 other function untouched", d, 8'h00);
        wr(12'h422, 8'hFF);
        rd(12'h422, d); check("R1 unmapped reads 0", d, 8'h00);
        rd(A1, d); check("R1 unmapped write ignored", d, 8'h00);
        wr(A0, 8'h00);
        rd(A0, d); check("R2 cleared", d, 8'h00);
    endtask

    task automatic t_live();
        logic [7:0] d;
        irq_src[1] = 1'b1;
        tick(1);
        rd(A1, d); check("R4 live follows request", d, 8'h02);
        check("R11 ireq_n low", {7'd0, ireq_n}, 8'h00);
        wr(A1, 8'h00);
        rd(A1, d); check("R4 write to bit1 ignored", d, 8'h02);
        irq_src[1] = 1'b0;
        tick(1);
        rd(A1, d); check("R4 live clears with request", d, 8'h00);
        check("R11 ireq_n high", {7'd0, ireq_n}, 8'h01);
    endtask

    task automatic t_sticky();
        logic [7:0] d;
        wr(A0, 8'h01);
        irq_src[0] = 1'b1;
        tick(1);
        irq_src[0] = 1'b0;
        tick(3);
        rd(A0, d); check("R5 sticky holds", d, 8'h03);
        check("R11 ireq_n low on sticky", {7'd0, ireq_n}, 8'h00);
        wr(A0, 8'h03);
        rd(A0, d); check("R5 writing 1 no effect", d, 8'h03);
        wr(A0, 8'h01);
        rd(A0, d); check("R5 writing 0 clears", d, 8'h01);
        check("R11 ireq_n released", {7'd0, ireq_n}, 8'h01);
    endtask

    task automatic t_relatch();
        logic [7:0] d;
        irq_src[0] = 1'b1;
        tick(1);
        wr(A0, 8'h01);
        rd(A0, d); check("R6 low right after clear", d, 8'h01);
        tick(1);
        rd(A0, d); check("R6 relatched next clock", d, 8'h03);
        irq_src[0] = 1'b0;
        wr(A0, 8'h01);
        wr(A0, 8'h00);
        rd(A0, d); check("R6 cleanup", d, 8'h00);
    endtask

    task automatic t_chng();
        logic [7:0] d;
        io_mode = 1'b1;
        pin_status[7] = 1'b1;
        tick(1);
        rd(A1, d); check("R7 change-seen set", d, 8'h80);
        rd(A0, d); check("R7 other function clear", d, 8'h00);
        check("R8 no enable, chg_n high", {7'd0, chg_n}, 8'h01);
        wr(A1, 8'h40);
        check("R8 enabled in io mode, chg_n low", {7'd0, chg_n}, 8'h00);
        io_mode = 1'b0;
        #0.5;
        check("R8 not io mode, chg_n high", {7'd0, chg_n}, 8'h01);
        io_mode = 1'b1;
        pin_status[7] = 1'b0;
        pin_status[4] = 1'b1;
        tick(1);
        rd(A1, d); check("R7 another pin bit", d, 8'hC0);
        pin_status = '0;
        tick(1);
        rd(A1, d); check("R7 cleared", d, 8'h40);
        check("R8 chg_n high when no change", {7'd0, chg_n}, 8'h01);
        wr(A1, 8'h00);
    endtask

    task automatic t_audio();
        wr(A0, 8'h08);
        io_mode = 1'b1;
        audio_in = 2'b01;
        #0.5;
        check("R9 enabled audio passes", {7'd0, spkr_out}, 8'h01);
        audio_in = 2'b10;
        #0.5;
        check("R9 disabled function blocked", {7'd0, spkr_out}, 8'h00);
        audio_in = 2'b01;
        io_mode = 1'b0;
        #0.5;
        check("R9 not io mode blocked", {7'd0, spkr_out}, 8'h00);
        audio_in = 2'b00;
        wr(A0, 8'h00);
    endtask

    task automatic t_pwrdn();
        logic [7:0] d;
        ready = 1'b0;
        wr(A0, 8'h04);
        tick(2);
        rd(A0, d); check("R10 bit readback", d, 8'h04);
        check("R10 held while busy", {6'd0, pwrdn_req}, 8'h00);
        ready = 1'b1;
        tick(1);
        check("R10 applied when ready", {6'd0, pwrdn_req}, 8'h01);
        ready = 1'b0;
        wr(A0, 8'h00);
        tick(1);
        check("R10 release held while busy", {6'd0, pwrdn_req}, 8'h01);
        ready = 1'b1;
        tick(1);
        check("R10 release when ready", {6'd0, pwrdn_req}, 8'h00);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_map();
        t_live();
        t_sticky();
        t_relatch();
        t_chng();
        t_audio();
        t_pwrdn();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule